// File: doc/BRIEF.md
# Host-to-Processor Parallel Transfer Port

This block carries 24-bit words from an external host over an 8-bit parallel bus into an on-chip processor. The host loads a word one byte at a time into three transmit byte registers (high, middle, low). Writing the low byte commits the word. The port then moves the word into a 24-bit receive register as soon as that register is free, and it tells the processor that data is waiting. The processor drains the word with a read strobe, which frees the receive register for the next word.

Both sides see handshake flags. The host polls a status byte or waits on an active-low request line that fires when the transmit path is empty. The processor polls its own status byte or takes an interrupt. A two-bit mode field in the host control byte selects either interrupt-driven operation or one of three DMA widths (24, 16 or 8 bits per transfer). In the narrower DMA modes the host loads only the lower bytes, and the upper bytes it leaves alone are reused. Two host-to-processor flags and two processor-to-host flags pass between the control and status bytes of the two sides.

Top module: `host_rx_port`

## Requirements
- R1: After a synchronous reset the port reports transmit-empty 1 and receive-full 0, both control bytes read 0, the mode is interrupt mode, h_req_n is 1 and p_irq is 0. The host status byte reads 0x06 and the processor status byte reads 0x00.
- R2: Host writes to address 5, 6 and 7 load the high, middle and low transmit bytes. A write to address 7 clears transmit-empty (host status bit 1) on the clock edge that takes the write.
- R3: On the clock edge after transmit-empty goes to 0 while receive-full is 0, p_rx_data takes {high, middle, low}, receive-full (processor status bit 0) becomes 1 and transmit-empty returns to 1. Words reach the processor in commit order.
- R4: A p_rx_rd strobe taken on a clock edge clears receive-full after that edge. While receive-full is 1, a committed word waits in the transmit bytes with transmit-empty 0, and p_rx_data holds its value.
- R5: Transmitter-ready (host status bit 2) is 1 only when transmit-empty is 1 and receive-full is 0.
- R6: h_req_n is 0, and host status bit 7 is 1, exactly when transmit-empty is 1 and the transmit-request enable (host control bit 1) is 1. With the enable at 0 the request is masked.
- R7: p_irq is 1 exactly when the receive interrupt enable (processor control bit 0) is 1 and receive-full is 1. p_irq_vec always carries the vector 0x30.
- R8: Host control bits 6:5 set the mode: 00 interrupt (DMA off), 01 24-bit DMA, 10 16-bit DMA, 11 8-bit DMA. Processor status bit 7 is 1 in any DMA mode and 0 in interrupt mode.
- R9: Host control bits 4:3 (flags 1:0) appear in processor status bits 4:3. Processor control bits 4:3 (flags 3:2) appear in host status bits 4:3. Host control keeps only bits 6,5,4,3,1,0 and processor control keeps only bits 4,3,0. Other bits read back 0.
- R10: A word committed after writing only the low byte, or only the middle and low bytes, carries the previously written upper bytes.
- R11: A low-byte write on the same edge as a transfer sends the older word to the receive register and leaves the newer word pending with transmit-empty 0. The newer word transfers once the processor drains the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 3 | Host register address (0 control, 2 status, 5/6/7 transmit high/middle/low) |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for h_addr |
| h_req_n | output | 1 | Active-low host request |
| p_rx_rd | input | 1 | Processor read strobe for the receive register |
| p_rx_data | output | 24 | Receive register |
| p_stat | output | 8 | Processor status byte |
| p_ctrl_wr | input | 1 | Processor control write strobe |
| p_ctrl_wdata | input | 8 | Processor control write data |
| p_ctrl | output | 8 | Processor control byte |
| p_irq | output | 1 | Receive interrupt |
| p_irq_vec | output | 8 | Interrupt vector address |

## Verification
The transfer path is driven in several ways. Full three-byte words show that all byte lanes land in the correct positions. Low-only and middle-plus-low loads separate a design that keeps the stale upper bytes from one that clears them. A word committed while the receive register is still full shows whether the port holds the word or overwrites it. Two low-byte writes on consecutive edges place a commit on the same edge as a transfer, which exposes a wrong priority between clearing and refilling transmit-empty. A stream of varied words, drained automatically, checks ordering through the expected-word queue.

// File: rtl/host_rx_pkg.sv
// Shared types and register layout for the host-to-processor transfer port.
// Assumes byte-wide registers of at least 8 bits.
package host_rx_pkg;

    typedef enum logic [1:0] {
        HM_IRQ   = 2'b00,
        HM_DMA24 = 2'b01,
        HM_DMA16 = 2'b10,
        HM_DMA8  = 2'b11
    } host_mode_e;

    // Host addresses
    localparam int ADR_CTRL  = 0;
    localparam int ADR_STAT  = 2;
    localparam int ADR_TX_LO = 7;   // high byte sits at ADR_TX_LO-2

    // Host control bits
    localparam int HC_RREQ = 0;
    localparam int HC_TREQ = 1;
    localparam int HC_FL0  = 3;
    localparam int HC_FL1  = 4;
    localparam int HC_MLO  = 5;
    localparam int HC_MHI  = 6;

    // Host status bits
    localparam int HS_TXDE = 1;
    localparam int HS_TRDY = 2;
    localparam int HS_FL2  = 3;
    localparam int HS_FL3  = 4;
    localparam int HS_REQ  = 7;

    // Processor status bits
    localparam int PS_FULL = 0;
    localparam int PS_FL0  = 3;
    localparam int PS_FL1  = 4;
    localparam int PS_DMA  = 7;

    // Processor control bits
    localparam int PC_RIE  = 0;
    localparam int PC_FL2  = 3;
    localparam int PC_FL3  = 4;

    function automatic logic mode_uses_dma(host_mode_e m);
        return m != HM_IRQ;
    endfunction

endpackage

// File: rtl/host_rx_xfer.sv
// Transfer core: owns the transmit-empty and receive-full flags and the
// receive register. Assumes the commit pulse comes from a host low-byte write.
module host_rx_xfer
    import host_rx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              commit,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_word,
    output logic              txde,
    output logic              hrdf
);

    logic move;
    assign move = !txde && !hrdf;

    // Receive register and receive-full flag: load on move, clear on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
            hrdf    <= 1'b0;
        end else if (move) begin
            rx_word <= tx_word;
            hrdf    <= 1'b1;
        end else if (rx_rd) begin
            hrdf    <= 1'b0;
        end
    end

    // Transmit-empty flag: a new commit wins over the refill from a move
    always_ff @(posedge clk) begin
        if (!rst_n)      txde <= 1'b1;
        else if (commit) txde <= 1'b0;
        else if (move)   txde <= 1'b1;
    end

    p_commit_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !txde);
    p_move_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!txde && !hrdf) |=> (hrdf && rx_word == $past(tx_word)));
    p_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!txde && !hrdf && !commit) |=> txde);
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && hrdf) |=> !hrdf);
    p_hold_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hrdf && !rx_rd) |=> (hrdf && $stable(rx_word)));

endmodule

// File: rtl/host_rx_hostside.sv
// Host-side registers: transmit bytes, host control byte, host read mux and
// request line. Assumes single-cycle write strobes and combinational reads.
module host_rx_hostside
    import host_rx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 3,
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic [BYTE_W-1:0] h_wdata,
    input  logic              txde,
    input  logic              hrdf,
    input  logic [1:0]        flags_dn,
    output logic [WORD_W-1:0] tx_word,
    output logic              commit,
    output host_mode_e        mode,
    output logic [1:0]        flags_up,
    output logic [BYTE_W-1:0] h_rdata,
    output logic              h_req_n
);

    localparam logic [BYTE_W-1:0] HC_MASK = BYTE_W'((1 << HC_MHI) | (1 << HC_MLO) |
        (1 << HC_FL1) | (1 << HC_FL0) | (1 << HC_TREQ) | (1 << HC_RREQ));

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] stat_b;
    logic              req;
    logic              trdy;

    // One transmit byte register per lane, lane 0 at the low-byte address
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_tx
        logic [BYTE_W-1:0] byte_q;
        logic              sel;
        assign sel = h_wr && (h_addr == ADDR_W'(ADR_TX_LO - b));
        // Load this lane on its host write
        always_ff @(posedge clk) begin
            if (!rst_n)   byte_q <= '0;
            else if (sel) byte_q <= h_wdata;
        end
        assign tx_word[b*BYTE_W +: BYTE_W] = byte_q;
    end

    assign commit = h_wr && (h_addr == ADDR_W'(ADR_TX_LO));

    // Host control byte, undefined bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (h_wr && h_addr == ADDR_W'(ADR_CTRL))
            ctrl_q <= h_wdata & HC_MASK;
    end

    assign mode     = host_mode_e'(ctrl_q[HC_MHI:HC_MLO]);
    assign flags_up = {ctrl_q[HC_FL1], ctrl_q[HC_FL0]};
    assign req      = txde && ctrl_q[HC_TREQ];
    assign trdy     = txde && !hrdf;
    assign h_req_n  = !req;

    // Assemble the host status byte
    always_comb begin
        stat_b          = '0;
        stat_b[HS_REQ]  = req;
        stat_b[HS_FL3]  = flags_dn[1];
        stat_b[HS_FL2]  = flags_dn[0];
        stat_b[HS_TRDY] = trdy;
        stat_b[HS_TXDE] = txde;
    end

    // Host read mux
    always_comb begin
        if (h_addr == ADDR_W'(ADR_CTRL))      h_rdata = ctrl_q;
        else if (h_addr == ADDR_W'(ADR_STAT)) h_rdata = stat_b;
        else                                  h_rdata = '0;
    end

    p_commit_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> h_req_n);
    p_req_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !h_req_n |-> ctrl_q[HC_TREQ]);

endmodule

// File: rtl/host_rx_procside.sv
// Processor-side control and status: receive interrupt gating, DMA indication
// and flag exchange. Assumes single-cycle control write strobes.
module host_rx_procside
    import host_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_ctrl_wr,
    input  logic [BYTE_W-1:0] p_ctrl_wdata,
    input  host_mode_e        mode,
    input  logic [1:0]        flags_up,
    input  logic              hrdf,
    output logic [BYTE_W-1:0] p_ctrl,
    output logic [BYTE_W-1:0] p_stat,
    output logic              p_irq,
    output logic [1:0]        flags_dn
);

    localparam logic [BYTE_W-1:0] PC_MASK =
        BYTE_W'((1 << PC_FL3) | (1 << PC_FL2) | (1 << PC_RIE));

    logic [BYTE_W-1:0] ctrl_q;

    // Processor control byte, undefined bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (p_ctrl_wr) ctrl_q <= p_ctrl_wdata & PC_MASK;
    end

    assign p_ctrl   = ctrl_q;
    assign flags_dn = {ctrl_q[PC_FL3], ctrl_q[PC_FL2]};
    assign p_irq    = ctrl_q[PC_RIE] && hrdf;

    // Assemble the processor status byte
    always_comb begin
        p_stat          = '0;
        p_stat[PS_DMA]  = mode_uses_dma(mode);
        p_stat[PS_FL1]  = flags_up[1];
        p_stat[PS_FL0]  = flags_up[0];
        p_stat[PS_FULL] = hrdf;
    end

    p_irq_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        p_irq |-> hrdf);
    p_irq_off_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[PC_RIE] |-> !p_irq);
    p_dma_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_IRQ) |-> !p_stat[PS_DMA]);

endmodule

// File: rtl/host_rx_port.sv
// Top of the host-to-processor transfer port: host registers, transfer core
// and processor registers. Assumes both sides share one clock.
module host_rx_port
    import host_rx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 3,
    parameter int VEC_W     = 8,
    parameter logic [VEC_W-1:0] IRQ_VEC = 'h30,
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic [BYTE_W-1:0] h_wdata,
    output logic [BYTE_W-1:0] h_rdata,
    output logic              h_req_n,
    input  logic              p_rx_rd,
    output logic [WORD_W-1:0] p_rx_data,
    output logic [BYTE_W-1:0] p_stat,
    input  logic              p_ctrl_wr,
    input  logic [BYTE_W-1:0] p_ctrl_wdata,
    output logic [BYTE_W-1:0] p_ctrl,
    output logic              p_irq,
    output logic [VEC_W-1:0]  p_irq_vec
);

    logic [WORD_W-1:0] tx_word;
    logic              commit;
    logic              txde;
    logic              hrdf;
    host_mode_e        mode;
    logic [1:0]        flags_up;
    logic [1:0]        flags_dn;

    host_rx_hostside #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_host (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
        .txde(txde), .hrdf(hrdf), .flags_dn(flags_dn), .tx_word(tx_word),
        .commit(commit), .mode(mode), .flags_up(flags_up), .h_rdata(h_rdata),
        .h_req_n(h_req_n)
    );

    host_rx_xfer #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_xfer (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .commit(commit),
        .rx_rd(p_rx_rd), .rx_word(p_rx_data), .txde(txde), .hrdf(hrdf)
    );

    host_rx_procside #(.BYTE_W(BYTE_W)) u_proc (
        .clk(clk), .rst_n(rst_n), .p_ctrl_wr(p_ctrl_wr), .p_ctrl_wdata(p_ctrl_wdata),
        .mode(mode), .flags_up(flags_up), .hrdf(hrdf), .p_ctrl(p_ctrl),
        .p_stat(p_stat), .p_irq(p_irq), .flags_dn(flags_dn)
    );

    assign p_irq_vec = IRQ_VEC;

    // Host-visible ready must agree with the processor-visible full flag
    p_trdy_vs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_addr == ADDR_W'(ADR_STAT) && h_rdata[HS_TRDY]) |-> !p_stat[PS_FULL]);

endmodule

// File: tb/host_rx_port_bench.sv
`timescale 1ns/1ps
module host_rx_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  h_addr = '0;
    logic        h_wr = 1'b0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic        h_req_n;
    logic        p_rx_rd = 1'b0;
    logic [23:0] p_rx_data;
    logic [7:0]  p_stat;
    logic        p_ctrl_wr = 1'b0;
    logic [7:0]  p_ctrl_wdata = '0;
    logic [7:0]  p_ctrl;
    logic        p_irq;
    logic [7:0]  p_irq_vec;

    int checks = 0;
    int fails  = 0;
    int rd_req = 0;
    int rd_done = 0;
    bit auto_drain = 1'b0;
    bit done = 1'b0;
    string sb_tag = "R3";
    logic [7:0] sh_hi = '0;
    logic [7:0] sh_mid = '0;
    logic [23:0] exp_q[$];

    always #4 clk = ~clk;

    host_rx_port u_host_rx_port (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_req_n(h_req_n), .p_rx_rd(p_rx_rd), .p_rx_data(p_rx_data),
        .p_stat(p_stat), .p_ctrl_wr(p_ctrl_wr), .p_ctrl_wdata(p_ctrl_wdata),
        .p_ctrl(p_ctrl), .p_irq(p_irq), .p_irq_vec(p_irq_vec)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // All tasks start and end just after a falling edge
    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        if (a == 3'd5) sh_hi = d;
        if (a == 3'd6) sh_mid = d;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        h_addr = a;
        #1 d = h_rdata;
    endtask

    task automatic proc_wr(input logic [7:0] d);
        p_ctrl_wdata = d; p_ctrl_wr = 1'b1;
        @(negedge clk);
        p_ctrl_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: loads a full word and queues its expected value
    task automatic send_word(input logic [23:0] w);
        host_wr(3'd5, w[23:16]);
        host_wr(3'd6, w[15:8]);
        exp_q.push_back(w);
        host_wr(3'd7, w[7:0]);
    endtask

    // Driver: commits with only the low byte written
    task automatic send_lo(input logic [7:0] lo);
        exp_q.push_back({sh_hi, sh_mid, lo});
        host_wr(3'd7, lo);
    endtask

    // Monitor: drains the receive register and compares against the queue
    always @(negedge clk) begin
        if (p_rx_rd) begin
            p_rx_rd = 1'b0;
        end else if (rst_n && p_stat[0] && (auto_drain || rd_req != rd_done)) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL %s unexpected word actual=%0h expected=none", sb_tag, p_rx_data);
            end else begin
                check_eq(sb_tag, {8'h0, p_rx_data}, {8'h0, exp_q.pop_front()});
            end
            p_rx_rd = 1'b1;
            if (rd_req != rd_done) rd_done++;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [23:0] lfsr;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_rd(3'd2, d); check_eq("R1 host status", d, 8'h06);
        host_rd(3'd0, d); check_eq("R1 host control", d, 8'h00);
        check_eq("R1 proc status", p_stat, 8'h00);
        check_eq("R1 proc control", p_ctrl, 8'h00);
        check_eq("R1 h_req_n", h_req_n, 1'b1);
        check_eq("R1 p_irq", p_irq, 1'b0);

        // R2/R3/R5 single word, manual drain
        sb_tag = "R3";
        host_wr(3'd5, 8'h12);
        host_wr(3'd6, 8'h34);
        exp_q.push_back(24'h123456);
        host_wr(3'd7, 8'h56);
        host_rd(3'd2, d); check_eq("R2 txde clear after low write", d[1], 1'b0);
        check_eq("R5 trdy low while txde 0", d[2], 1'b0);
        wait_n(1);
        check_eq("R3 word moved", p_rx_data, 24'h123456);
        check_eq("R3 full set", p_stat[0], 1'b1);
        host_rd(3'd2, d); check_eq("R3 txde set again", d[1], 1'b1);
        check_eq("R5 trdy low while full", d[2], 1'b0);
        rd_req++; wait_n(3);
        check_eq("R4 read clears full", p_stat[0], 1'b0);
        host_rd(3'd2, d); check_eq("R5 trdy high when both empty", d[2], 1'b1);

        // R4 hold while full
        sb_tag = "R4";
        send_word(24'hA1A2A3); wait_n(1);
        send_word(24'hB1B2B3); wait_n(3);
        check_eq("R4 full held", p_stat[0], 1'b1);
        host_rd(3'd2, d); check_eq("R4 txde stays 0", d[1], 1'b0);
        check_eq("R4 rx held", p_rx_data, 24'hA1A2A3);
        rd_req++; wait_n(4);
        check_eq("R4 pending word moves after read", p_rx_data, 24'hB1B2B3);
        check_eq("R4 full again", p_stat[0], 1'b1);
        rd_req++; wait_n(3);
        check_eq("R4 drained", p_stat[0], 1'b0);

        // R11 commit on a transfer edge
        sb_tag = "R11";
        send_lo(8'hA0);
        send_lo(8'hB0);
        check_eq("R11 older word moved", p_rx_data, {sh_hi, sh_mid, 8'hA0});
        host_rd(3'd2, d); check_eq("R11 newer word pending", d[1], 1'b0);
        rd_req++; wait_n(3);
        check_eq("R11 newer word moved", p_rx_data, {sh_hi, sh_mid, 8'hB0});
        check_eq("R11 full", p_stat[0], 1'b1);
        rd_req++; wait_n(3);

        // R10 partial loads in narrow DMA modes
        sb_tag = "R10";
        auto_drain = 1'b1;
        send_word(24'hC1C2C3); wait_n(4);
        host_wr(3'd0, 8'h60);
        send_lo(8'h44); wait_n(4);
        host_wr(3'd0, 8'h40);
        host_wr(3'd6, 8'h55);
        send_lo(8'h66); wait_n(4);
        check_eq("R10 middle+low keeps high", p_rx_data, 24'hC15566);

        // R8 mode decode
        for (int m = 0; m < 4; m++) begin
            host_wr(3'd0, 8'(m << 5));
            check_eq("R8 dma flag", p_stat[7], (m != 0));
            host_rd(3'd0, d); check_eq("R8 mode readback", d, 8'(m << 5));
        end

        // R6 request gating
        sb_tag = "R6";
        host_wr(3'd0, 8'h02);
        check_eq("R6 request asserted", h_req_n, 1'b0);
        host_rd(3'd2, d); check_eq("R6 request status bit", d[7], 1'b1);
        send_word(24'h0D0E0F);
        check_eq("R6 request drops on commit", h_req_n, 1'b1);
        wait_n(4);
        check_eq("R6 request back when empty", h_req_n, 1'b0);
        host_wr(3'd0, 8'h00);
        check_eq("R6 request masked", h_req_n, 1'b1);

        // R7 receive interrupt
        sb_tag = "R7";
        auto_drain = 1'b0;
        proc_wr(8'h01);
        check_eq("R7 no irq when empty", p_irq, 1'b0);
        send_word(24'h777777); wait_n(1);
        check_eq("R7 irq with data", p_irq, 1'b1);
        check_eq("R7 vector", p_irq_vec, 8'h30);
        proc_wr(8'h00);
        check_eq("R7 irq masked", p_irq, 1'b0);
        proc_wr(8'h01);
        check_eq("R7 irq re-enabled", p_irq, 1'b1);
        rd_req++; wait_n(3);
        check_eq("R7 irq gone after read", p_irq, 1'b0);
        proc_wr(8'h00);

        // R9 flag exchange and masking
        host_wr(3'd0, 8'h18);
        check_eq("R9 flags 1:0 to processor", p_stat, 8'h18);
        host_wr(3'd0, 8'h08);
        check_eq("R9 flag 0 only", p_stat, 8'h08);
        proc_wr(8'h10);
        host_rd(3'd2, d); check_eq("R9 flag 3 to host", d, 8'h16);
        proc_wr(8'h08);
        host_rd(3'd2, d); check_eq("R9 flag 2 to host", d, 8'h0E);
        host_wr(3'd0, 8'hFF);
        host_rd(3'd0, d); check_eq("R9 host control mask", d, 8'h7B);
        proc_wr(8'hFF);
        check_eq("R9 proc control mask", p_ctrl, 8'h19);
        host_wr(3'd0, 8'h00);
        proc_wr(8'h00);

        // R3 scoreboard stream
        sb_tag = "R3";
        auto_drain = 1'b1;
        lfsr = 24'h5A5A5A;
        for (int i = 0; i < 20; i++) begin
            lfsr = lfsr * 24'd1103 + 24'd12345;
            send_word(lfsr);
            if (i % 3 == 0) wait_n(2);
        end
        wait_n(10);
        check_eq("R3 queue empty", exp_q.size(), 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule